// File: doc/BRIEF.md
# Double-Buffered SPI Master with Bus-Contention Hold

This block is an SPI master for a host that moves one byte at a time. A holding register for the outgoing byte and a holding register for the incoming byte sit on either side of one shift engine. When the host writes a byte, a full-duplex character transfer starts. The engine drives the serial clock and the outgoing data line and samples the incoming data line. Two flags report to the host. The transmit-ready flag says the holding register can take another byte. The receive-done flag says a complete byte has come back. The host gets a byte back only by sending one.

The serial clock comes from the system clock through a programmable divider. Its idle level, its sampling phase and the bit order are set by configuration inputs. In 4-pin mode a contention input takes the master off the bus whenever it is away from its configured active level:

- both output enables drop;
- a sticky fault bit is set;
- the character in flight is thrown away.

A byte that is waiting in the holding register is kept, and it goes out once the input returns to its active level. In 3-pin mode the contention input has no effect.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, tx_ready is 1, rx_done is 0, fault is 0, both output enables are 1, and sclk_o equals cfg_cpol.
- R2: The system clock edge that samples tx_wr clears tx_ready. On the next edge, if the engine is idle and not held, the byte moves into the shift register and tx_ready returns to 1. A transfer in progress does not clear tx_ready.
- R3: With cfg_msb_first=0 the byte is sent and received bit 0 first. With cfg_msb_first=1 it is sent and received bit 7 first.
- R4: sclk_o rests at cfg_cpol. The leading edge is the first transition away from cfg_cpol. With cfg_cpha=0, miso_i is sampled on leading edges and mosi_o changes on trailing edges. With cfg_cpha=1 the two are swapped, and bit one is valid before the first leading edge.
- R5: Each serial clock half-period lasts cfg_div+1 system clocks. rx_done rises 1+16*(cfg_div+1) system clock edges after the edge that samples tx_wr.
- R6: At the end of the eighth bit, rx_data takes the received byte and rx_done is set. A rx_rd pulse clears rx_done.
- R7: A byte written while another is shifting is started as soon as the first completes. Each completed byte raises rx_done with its own data.
- R8: In 4-pin mode (cfg_four_pin=1), while ste_i differs from cfg_ste_level the master is held:
  - one edge later sclk_oe and mosi_oe are 0 and fault is 1;
  - the character being shifted is lost, with no rx_done and no resend.
- R9: A byte written while the master is held stays buffered, with tx_ready at 0. It is transferred once ste_i returns to cfg_ste_level.
- R10: fault stays 1 until a fault_clr pulse arrives while the master is not held.
- R11: With cfg_four_pin=0, ste_i is ignored: outputs stay enabled, fault stays 0 and transfers complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_msb_first | input | 1 | 1: bit 7 first, 0: bit 0 first |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_four_pin | input | 1 | Enables the contention input |
| cfg_ste_level | input | 1 | Level of ste_i that lets the master drive |
| cfg_div | input | DIVW | Half-period length minus one, in system clocks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | W | Byte to send |
| tx_ready | output | 1 | Transmit holding register can take a byte |
| rx_rd | input | 1 | Read strobe, clears rx_done |
| rx_data | output | W | Last received byte |
| rx_done | output | 1 | A byte has been received |
| fault | output | 1 | Sticky contention fault |
| fault_clr | input | 1 | Clears fault |
| ste_i | input | 1 | Contention input |
| miso_i | input | 1 | Serial data in |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi_o |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Output enable for sclk_o |

## Verification
tx_ready falls at the edge that samples the write and rises one edge later. rx_done rises exactly 1+16*(cfg_div+1) edges after the write. The output enables and fault respond one edge after ste_i changes. The bench samples each of these on the falling clock edge, after counting exactly that many rising edges, and checks the level on the cycle before the expected change as well as after it. A behavioural slave follows the serial clock edges, so the bit order and clock phase are checked from the serial lines themselves for all eight mode combinations and two divider settings.

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int W    = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_msb_first,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_four_pin,
  input  logic            cfg_ste_level,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            tx_wr,
  input  logic [W-1:0]    tx_data,
  output logic            tx_ready,
  input  logic            rx_rd,
  output logic [W-1:0]    rx_data,
  output logic            rx_done,
  output logic            fault,
  input  logic            fault_clr,
  input  logic            ste_i,
  input  logic            miso_i,
  output logic            mosi_o,
  output logic            mosi_oe,
  output logic            sclk_o,
  output logic            sclk_oe
);
  localparam int EW = $clog2(2 * W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);

  logic [W-1:0]    tx_buf, sr, rx_sr, rx_next;
  logic            tx_full, busy, lvl, oe;
  logic [DIVW-1:0] cnt;
  logic [EW-1:0]   edge_n;
  logic            held, tick, lead, sample_e, change_e, last, load;

  assign held     = cfg_four_pin && (ste_i != cfg_ste_level);
  assign tick     = busy && (cnt == cfg_div);
  assign lead     = ~edge_n[0];
  assign sample_e = tick && (lead ^ cfg_cpha);
  assign change_e = tick && !(lead ^ cfg_cpha) && (edge_n != '0);
  assign last     = tick && (edge_n == LAST_EDGE) && !held;
  assign load     = !busy && tx_full && !held;
  assign rx_next  = cfg_msb_first ? {rx_sr[W-2:0], miso_i} : {miso_i, rx_sr[W-1:1]};

  assign mosi_o  = cfg_msb_first ? sr[W-1] : sr[0];
  assign sclk_o  = cfg_cpol ^ lvl;
  assign mosi_oe = oe;
  assign sclk_oe = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      tx_full  <= 1'b0;
      tx_ready <= 1'b1;
    end else if (tx_wr) begin
      tx_buf   <= tx_data;
      tx_full  <= 1'b1;
      tx_ready <= 1'b0;
    end else if (load) begin
      tx_full  <= 1'b0;
      tx_ready <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      rx_sr   <= '0;
      rx_data <= '0;
      busy    <= 1'b0;
      lvl     <= 1'b0;
      cnt     <= '0;
      edge_n  <= '0;
      fault   <= 1'b0;
      oe      <= 1'b1;
    end else begin
      oe <= !held;
      if (held) begin
        busy   <= 1'b0;
        lvl    <= 1'b0;
        cnt    <= '0;
        edge_n <= '0;
        fault  <= 1'b1;
      end else begin
        if (fault_clr) fault <= 1'b0;
        if (load) begin
          sr     <= tx_buf;
          busy   <= 1'b1;
          lvl    <= 1'b0;
          cnt    <= '0;
          edge_n <= '0;
        end else if (tick) begin
          cnt    <= '0;
          lvl    <= ~lvl;
          edge_n <= edge_n + 1'b1;
          if (sample_e) rx_sr <= rx_next;
          if (change_e) sr <= cfg_msb_first ? {sr[W-2:0], 1'b0} : {1'b0, sr[W-1:1]};
          if (last) begin
            busy    <= 1'b0;
            rx_data <= sample_e ? rx_next : rx_sr;
          end
        end else if (busy) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_done <= 1'b0;
    else if (last)   rx_done <= 1'b1;
    else if (rx_rd)  rx_done <= 1'b0;
  end
endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_four_pin,
  input logic cfg_ste_level,
  input logic cfg_cpol,
  input logic ste_i,
  input logic tx_wr,
  input logic tx_ready,
  input logic rx_done,
  input logic fault,
  input logic fault_clr,
  input logic sclk_o,
  input logic sclk_oe,
  input logic mosi_oe
);
  logic held_c;
  assign held_c = cfg_four_pin && (ste_i != cfg_ste_level);

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held_c |=> (!sclk_oe && !mosi_oe && fault));

  assert_three_pin_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_four_pin |=> (sclk_oe && mosi_oe));

  assert_write_clears_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_ready);

  assert_done_clock_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (sclk_o == cfg_cpol));

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !held_c) |=> !fault);
endmodule

bind spi_dbuf_master spi_dbuf_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_four_pin(cfg_four_pin), .cfg_ste_level(cfg_ste_level),
  .cfg_cpol(cfg_cpol), .ste_i(ste_i), .tx_wr(tx_wr), .tx_ready(tx_ready),
  .rx_done(rx_done), .fault(fault), .fault_clr(fault_clr), .sclk_o(sclk_o),
  .sclk_oe(sclk_oe), .mosi_oe(mosi_oe)
);

// File: tb/spi_dbuf_master_tb.sv
module spi_dbuf_master_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_msb_first = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_four_pin = 0, cfg_ste_level = 1;
  logic [7:0] cfg_div = 0;
  logic tx_wr = 0, rx_rd = 0, fault_clr = 0, ste_i = 1, miso_i = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, rx_done, fault, mosi_o, mosi_oe, sclk_o, sclk_oe;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  logic [7:0] slv_tx [4];
  logic [7:0] slv_rx [4];
  int ecnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dbuf_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_four_pin(cfg_four_pin), .cfg_ste_level(cfg_ste_level),
    .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_done(rx_done), .fault(fault),
    .fault_clr(fault_clr), .ste_i(ste_i), .miso_i(miso_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .sclk_o(sclk_o), .sclk_oe(sclk_oe)
  );

  function automatic int pos(input int k);
    return cfg_msb_first ? 7 - k : k;
  endfunction

  // behavioural slave following the serial clock
  always @(sclk_o) begin : slave
    int e, c, k;
    e = ecnt % 16;
    c = (ecnt / 16) % 4;
    k = e / 2;
    if (((e % 2) == 0) != cfg_cpha) begin
      slv_rx[c][pos(k)] = mosi_o;
    end else if (cfg_cpha) begin
      miso_i = slv_tx[c][pos(k)];
    end else begin
      k = (e + 1) / 2;
      if (k < 8) miso_i = slv_tx[c][pos(k)];
      else if (c < 3) miso_i = slv_tx[c + 1][pos(0)];
    end
    ecnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slave_prep(input logic [7:0] s0, input logic [7:0] s1);
    slv_tx[0] = s0; slv_tx[1] = s1;
    slv_rx[0] = 8'h00; slv_rx[1] = 8'h00;
    ecnt = 0;
    if (!cfg_cpha) miso_i = s0[pos(0)];
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic read_clear;
    rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk(rx_done == 0, "R6 rx_rd clears rx_done", int'(rx_done), 0);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !rx_done; i++) @(negedge clk);
  endtask

  // timed single transfer
  task automatic xfer(input logic [7:0] d, input logic [7:0] s);
    int h;
    h = int'(cfg_div) + 1;
    slave_prep(s, 8'h00);
    write_byte(d);
    chk(tx_ready == 0, "R2 tx_ready low after write", int'(tx_ready), 0);
    @(negedge clk);
    chk(tx_ready == 1, "R2 tx_ready back after move", int'(tx_ready), 1);
    repeat (16 * h - 1) @(negedge clk);
    chk(rx_done == 0, "R5 rx_done not yet", int'(rx_done), 0);
    @(negedge clk);
    chk(rx_done == 1, "R5 rx_done on time", int'(rx_done), 1);
    chk(rx_data == s, "R3 R6 received byte", int'(rx_data), int'(s));
    chk(slv_rx[0] == d, "R3 R4 sent byte at slave", int'(slv_rx[0]), int'(d));
    read_clear();
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    logic [7:0] pats [3];
    pats[0] = 8'hA5; pats[1] = 8'h01; pats[2] = 8'h6E;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(tx_ready == 1, "R1 tx_ready", int'(tx_ready), 1);
    chk(rx_done == 0, "R1 rx_done", int'(rx_done), 0);
    chk(fault == 0, "R1 fault", int'(fault), 0);
    chk(sclk_oe && mosi_oe, "R1 enables", int'({sclk_oe, mosi_oe}), 3);
    chk(sclk_o == cfg_cpol, "R1 sclk idle", int'(sclk_o), int'(cfg_cpol));

    // sweep over divider, clock mode and bit order (R3 R4 R5)
    for (int dv = 0; dv < 2; dv++)
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 3; p++) begin
          @(negedge clk);
          cfg_div = 8'(dv); cfg_cpol = m[0]; cfg_cpha = m[1]; cfg_msb_first = m[2];
          @(negedge clk);
          chk(sclk_o == cfg_cpol, "R4 idle level", int'(sclk_o), int'(cfg_cpol));
          xfer(pats[p] ^ 8'(m * 17), ~pats[p] + 8'(dv));
        end

    // R7 back-to-back
    @(negedge clk);
    cfg_div = 1; cfg_cpol = 1; cfg_cpha = 1; cfg_msb_first = 0;
    @(negedge clk);
    slave_prep(8'h3C, 8'hC7);
    write_byte(8'h81);
    @(negedge clk);
    write_byte(8'h5A);
    chk(tx_ready == 0, "R7 second byte buffered", int'(tx_ready), 0);
    wait_done(200);
    chk(rx_data == 8'h3C, "R7 first received", int'(rx_data), 8'h3C);
    read_clear();
    wait_done(200);
    chk(rx_data == 8'hC7, "R7 second received", int'(rx_data), 8'hC7);
    chk(slv_rx[0] == 8'h81, "R7 first sent", int'(slv_rx[0]), 8'h81);
    chk(slv_rx[1] == 8'h5A, "R7 second sent", int'(slv_rx[1]), 8'h5A);
    read_clear();

    // R11 three-pin ignores ste_i
    @(negedge clk);
    cfg_four_pin = 0; cfg_ste_level = 1; ste_i = 0; cfg_cpha = 0; cfg_cpol = 0;
    @(negedge clk);
    xfer(8'hD2, 8'h4B);
    chk(fault == 0, "R11 no fault", int'(fault), 0);
    chk(sclk_oe == 1, "R11 still driving", int'(sclk_oe), 1);

    // R9 write while held, R8 enables and fault, R10 sticky fault
    @(negedge clk);
    cfg_four_pin = 1;
    @(negedge clk);
    chk(!sclk_oe && !mosi_oe, "R8 released", int'({sclk_oe, mosi_oe}), 0);
    chk(fault == 1, "R8 fault set", int'(fault), 1);
    slave_prep(8'h96, 8'h00);
    write_byte(8'h27);
    repeat (20) @(negedge clk);
    chk(tx_ready == 0, "R9 byte waits", int'(tx_ready), 0);
    chk(rx_done == 0, "R9 nothing sent while held", int'(rx_done), 0);
    ste_i = 1;
    wait_done(200);
    chk(rx_done == 1, "R9 sent after release", int'(rx_done), 1);
    chk(slv_rx[0] == 8'h27, "R9 sent byte", int'(slv_rx[0]), 8'h27);
    chk(rx_data == 8'h96, "R9 received byte", int'(rx_data), 8'h96);
    read_clear();
    chk(fault == 1, "R10 fault sticky", int'(fault), 1);
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    chk(fault == 0, "R10 fault cleared", int'(fault), 0);

    // R8 abort with active-low contention level
    @(negedge clk);
    cfg_ste_level = 0; ste_i = 0; cfg_div = 1;
    @(negedge clk);
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    slave_prep(8'hE1, 8'h00);
    write_byte(8'h99);
    repeat (10) @(negedge clk);
    ste_i = 1;
    @(negedge clk);
    chk(!sclk_oe && !mosi_oe, "R8 abort releases", int'({sclk_oe, mosi_oe}), 0);
    chk(fault == 1, "R8 abort fault", int'(fault), 1);
    repeat (4) @(negedge clk);
    ste_i = 0;
    repeat (60) @(negedge clk);
    chk(rx_done == 0, "R8 aborted byte lost", int'(rx_done), 0);
    chk(tx_ready == 1, "R8 no resend pending", int'(tx_ready), 1);
    chk(sclk_o == cfg_cpol, "R8 clock idle after abort", int'(sclk_o), int'(cfg_cpol));
    xfer(8'h99, 8'hE1);

    finish_up();
  end
endmodule